// File: doc/BRIEF.md
# Saturating Half-Word Arithmetic Shifter

This datapath unit takes one signed 16-bit half of a 32-bit source word and shifts it arithmetically. The shift amount is a small signed number held in the low half of a second word. A positive amount shifts left and a negative amount shifts right with sign extension. When a left shift cannot be represented in 16 signed bits, the unit can clamp the result to the largest value of the matching sign and raise an overflow flag. If clamping is turned off, the bits that do not fit are simply dropped.

The 16-bit result replaces one chosen half of the previous destination word. The other half of that word passes through unchanged. The merged word and the flag are registered, so they appear one clock after the operands are presented. Instruction decoding and register-file storage are the caller's concern.

Top module: `hw_sat_shifter`

## Requirements
- R1: While rst_n is low, result is 0x00000000 and ovf is 0.
- R2: Operands sampled at a rising clock edge appear on result and ovf right after that edge. They hold until the next edge.
- R3: A shift amount of zero returns the chosen source half unchanged, with ovf 0.
- R4: A positive amount k shifts left by k. When the value fits in 16 signed bits, the result is the plain shift and ovf is 0 (0xD002 by 1 gives 0xA004, 0xC005 by 1 gives 0x800A).
- R5: With sat_en high, a negative value whose left shift does not fit gives 0x8000. This covers 0x9001 by 1 and any negative value by 15 or by 16.
- R6: With sat_en high, a positive value whose left shift does not fit gives 0x7FFF.
- R7: A negative amount -m shifts right arithmetically by m. For m of 16 or more the result is 0x0000 when the input is non-negative and 0xFFFF when it is negative. ovf is 0.
- R8: Only bits [5:0] of cnt_word count, read as a two's-complement number from -32 to +31. Bits [31:6] have no effect.
- R9: src_hi = 1 takes bits [31:16] of src_word as the operand, and src_hi = 0 takes bits [15:0]. The unused half has no effect.
- R10: dst_hi = 1 writes the shifted half into result[31:16] and dst_hi = 0 writes it into result[15:0]. The other half of result equals the same half of dst_old.
- R11: ovf is 1 exactly when clamping changed the result. With sat_en low, an overflowing left shift yields the low 16 bits of the exact shifted value, and ovf is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_word | input | 32 | Word holding the operand half |
| src_hi | input | 1 | 1 selects the upper half of src_word, 0 the lower |
| cnt_word | input | 32 | Shift amount in bits [5:0], signed |
| dst_old | input | 32 | Previous destination word |
| dst_hi | input | 1 | 1 writes result[31:16], 0 writes result[15:0] |
| sat_en | input | 1 | Enables clamping on left-shift overflow |
| result | output | 32 | Merged destination word, registered |
| ovf | output | 1 | Clamping applied, registered |

## Verification
The unit holds no state beyond its output register. A wrong value in the overflow detector or in the right-shift path therefore appears on the next clock edge, in the written half of result. A wrong half selection shows in that same cycle as a corrupted kept half or a wrong operand. Sweeping every shift amount against boundary and scattered operand values, in all four half pairings with clamping on and off, exposes a mismatch within the single cycle that carries the faulty vector.

// File: rtl/hws_pkg.sv
package hws_pkg;
  // Which 16-bit half of a 32-bit word is addressed
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/hws_half_pick.sv
module hws_half_pick #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] word,
  input  logic                hi_sel,
  output logic [HALF_W-1:0]   half
);
  import hws_pkg::*;
  half_sel_e sel;
  assign sel  = half_sel_e'(hi_sel);
  assign half = (sel == HALF_HI) ? word[2*HALF_W-1:HALF_W] : word[HALF_W-1:0];
endmodule

// File: rtl/hws_shift_core.sv
module hws_shift_core #(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic [HALF_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              sat_en,
  output logic [HALF_W-1:0] dout,
  output logic              left_wrap,
  output logic              sat_hit
);
  localparam int MAX_L = (1 << (CNT_W - 1)) - 1;
  localparam int EXT_W = HALF_W + MAX_L;
  localparam logic [HALF_W-1:0] POS_LIM = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] NEG_LIM = {1'b1, {(HALF_W-1){1'b0}}};

  // sign-extend into a word wide enough for the largest left shift
  function automatic logic [EXT_W-1:0] shl_wide(input logic [HALF_W-1:0] v,
                                                input logic [CNT_W-2:0]  amt);
    logic [EXT_W-1:0] w;
    w = {{MAX_L{v[HALF_W-1]}}, v};
    return w << amt;
  endfunction

  // value fits in HALF_W signed bits when all bits above the sign agree
  function automatic logic fits_half(input logic [EXT_W-1:0] w);
    logic [EXT_W-HALF_W:0] top;
    top = w[EXT_W-1:HALF_W-1];
    return (&top) | (~|top);
  endfunction

  function automatic logic [HALF_W-1:0] asr_half(input logic [HALF_W-1:0] v,
                                                 input logic [CNT_W-1:0]  mag);
    logic signed [HALF_W-1:0] s;
    s = v;
    if (int'(mag) >= HALF_W) return {HALF_W{v[HALF_W-1]}};
    return s >>> mag;
  endfunction

  logic             neg;
  logic [CNT_W-1:0] mag;
  logic [EXT_W-1:0] wide;

  always_comb begin
    neg       = cnt[CNT_W-1];
    mag       = '0 - cnt;
    wide      = shl_wide(din, cnt[CNT_W-2:0]);
    left_wrap = !neg && !fits_half(wide);
    sat_hit   = left_wrap && sat_en;
    if (neg)          dout = asr_half(din, mag);
    else if (sat_hit) dout = din[HALF_W-1] ? NEG_LIM : POS_LIM;
    else              dout = wide[HALF_W-1:0];
  end
endmodule

// File: rtl/hws_merge.sv
module hws_merge #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] old_word,
  input  logic [HALF_W-1:0]   new_half,
  input  logic                hi_sel,
  output logic [2*HALF_W-1:0] word
);
  for (genvar g = 0; g < 2; g++) begin : g_half
    assign word[g*HALF_W +: HALF_W] = (hi_sel == 1'(g)) ? new_half
                                                        : old_word[g*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/hw_sat_shifter.sv
module hw_sat_shifter #(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_W-1:0] src_word,
  input  logic                src_hi,
  input  logic [2*HALF_W-1:0] cnt_word,
  input  logic [2*HALF_W-1:0] dst_old,
  input  logic                dst_hi,
  input  logic                sat_en,
  output logic [2*HALF_W-1:0] result,
  output logic                ovf
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] POS_LIM = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] NEG_LIM = {1'b1, {(HALF_W-1){1'b0}}};

  logic [HALF_W-1:0] picked;
  logic [HALF_W-1:0] shifted;
  logic              core_wrap;
  logic              core_sat;
  logic [WORD_W-1:0] merged;
  logic              primed_q;

  hws_half_pick #(.HALF_W(HALF_W)) u_pick (
    .word(src_word), .hi_sel(src_hi), .half(picked)
  );

  hws_shift_core #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_core (
    .din(picked), .cnt(cnt_word[CNT_W-1:0]), .sat_en(sat_en),
    .dout(shifted), .left_wrap(core_wrap), .sat_hit(core_sat)
  );

  hws_merge #(.HALF_W(HALF_W)) u_merge (
    .old_word(dst_old), .new_half(shifted), .hi_sel(dst_hi), .word(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      ovf      <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      result   <= merged;
      ovf      <= core_sat;
      primed_q <= 1'b1;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !$past(sat_en)) |-> !ovf);

  // R5 R6
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && ovf) |->
      (($past(dst_hi) ? result[WORD_W-1:HALF_W] : result[HALF_W-1:0]) == POS_LIM ||
       ($past(dst_hi) ? result[WORD_W-1:HALF_W] : result[HALF_W-1:0]) == NEG_LIM));

  // R10
  keep_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |->
      ($past(dst_hi) ? (result[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]))
                     : (result[WORD_W-1:HALF_W] == $past(dst_old[WORD_W-1:HALF_W]))));

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(cnt_word[CNT_W-1:0]) == '0) |->
      (!ovf && ($past(dst_hi) ? result[WORD_W-1:HALF_W] : result[HALF_W-1:0]) == $past(picked)));

  // R7
  right_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(cnt_word[CNT_W-1])) |-> !ovf);
endmodule

// File: tb/hw_sat_shifter_bench.sv
module hw_sat_shifter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_word = '0, cnt_word = '0, dst_old = '0;
  logic        src_hi = 1'b0, dst_hi = 1'b0, sat_en = 1'b0;
  logic [31:0] result;
  logic        ovf;

  int          checks = 0, errors = 0;
  logic [31:0] prev_res = '0;
  logic        prev_ovf = 1'b0;
  bit          done = 0;

  hw_sat_shifter u_hw_sat_shifter (
    .clk(clk), .rst_n(rst_n), .src_word(src_word), .src_hi(src_hi),
    .cnt_word(cnt_word), .dst_old(dst_old), .dst_hi(dst_hi), .sat_en(sat_en),
    .result(result), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // exact integer model of the requirements
  task automatic model(input logic [31:0] sw, input logic sh, input logic [31:0] cw,
                       input logic [31:0] od, input logic dh, input logic se,
                       output logic [31:0] r, output logic o, output string tag);
    longint v, p;
    int     c;
    logic [15:0] h;
    v = sh ? longint'($signed(sw[31:16])) : longint'($signed(sw[15:0]));
    c = cw[5] ? int'(cw[5:0]) - 64 : int'(cw[5:0]);
    o = 1'b0;
    if (c == 0) begin
      h = v[15:0]; tag = "R3";
    end else if (c < 0) begin
      tag = "R7";
      if (-c >= 16) h = (v < 0) ? 16'hFFFF : 16'h0000;
      else begin p = v >>> (-c); h = p[15:0]; end
    end else begin
      p = v <<< c;
      if (p > 32767 || p < -32768) begin
        if (se) begin
          o = 1'b1; h = (p > 0) ? 16'h7FFF : 16'h8000; tag = (p > 0) ? "R6" : "R5";
        end else begin
          h = p[15:0]; tag = "R11";
        end
      end else begin
        h = p[15:0]; tag = "R4";
      end
    end
    r = dh ? {h, od[15:0]} : {od[31:16], h};
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] sw, input logic sh, input logic [31:0] cw,
                       input logic [31:0] od, input logic dh, input logic se,
                       input string force_tag);
    logic [31:0] er;
    logic        eo;
    string       tag;
    src_word = sw; src_hi = sh; cnt_word = cw; dst_old = od; dst_hi = dh; sat_en = se;
    model(sw, sh, cw, od, dh, se, er, eo, tag);
    if (force_tag != "") tag = force_tag;
    #1;
    // R2: nothing moves before the edge
    chk("R2", "result before edge", result, prev_res);
    @(posedge clk);
    #1;
    chk(tag, "result", result, er);
    chk((eo || tag == "R11") ? "R11" : tag, "ovf", {31'b0, ovf}, {31'b0, eo});
    // R10: kept half
    if (dh) chk("R10", "kept low", {16'b0, result[15:0]}, {16'b0, od[15:0]});
    else    chk("R10", "kept high", {16'b0, result[31:16]}, {16'b0, od[31:16]});
    prev_res = er; prev_ovf = eo;
  endtask

  function automatic logic [15:0] pick_val(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h7FFF;  3: return 16'h8000;
      4: return 16'hFFFF;  5: return 16'hC001;  6: return 16'h9001;  7: return 16'hD002;
      8: return 16'hC005;  9: return 16'hF007; 10: return 16'h4000; 11: return 16'h3FFF;
      12: return 16'hBFFF; 13: return 16'h0100;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "reset result", result, 32'h0);
    chk("R1", "reset ovf", {31'b0, ovf}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(32'h0000_0003, 0, 32'h0, 32'h0, 0, 1, "R3");
    apply(32'h0000_D002, 0, 32'h1, 32'h0, 0, 1, "R4");
    apply(32'h0000_C005, 0, 32'h1, 32'h0, 0, 1, "R4");
    apply(32'h0000_9001, 0, 32'h1, 32'h0, 0, 1, "R5");
    apply(32'h0000_C001, 0, 32'hF,  32'h0, 0, 1, "R5");
    apply(32'h0000_F007, 0, 32'h10, 32'h0, 0, 1, "R5");
    apply(32'h0000_0001, 0, 32'hF,  32'h0, 0, 1, "R6");
    apply(32'h0000_4000, 0, 32'h1,  32'h0, 1, 1, "R6");
    apply(32'h0000_8000, 0, 32'h3F, 32'h0, 0, 1, "R7");
    apply(32'h0000_8000, 0, 32'h30, 32'h0, 0, 1, "R7");
    apply(32'h0000_7FFF, 0, 32'h20, 32'h0, 0, 1, "R7");
    apply(32'h0000_0001, 0, 32'hFFFF_FFC1, 32'h0, 0, 1, "R8");
    apply(32'h0000_0005, 0, 32'h1234_0040, 32'h0, 0, 1, "R8");
    apply(32'h9001_0000, 1, 32'h1, 32'hFFFF_FFFF, 0, 1, "R9");
    apply(32'h1234_0001, 0, 32'h1, 32'h0, 1, 1, "R9");
    apply(32'h0000_D001, 0, 32'h1, 32'h0000_D001, 1, 1, "R10");
    apply(32'h0000_9001, 0, 32'h1, 32'h0, 0, 0, "R11");

    // sweep every count against boundary and scattered operands, all modes
    for (int vi = 0; vi < 48; vi++) begin
      for (int c = 0; c < 64; c++) begin
        for (int m = 0; m < 8; m++) begin
          logic [15:0] opv, junk;
          opv  = pick_val(vi);
          junk = 16'($urandom);
          apply(m[0] ? {opv, junk} : {junk, opv}, m[0],
                {26'($urandom), 6'(c)}, $urandom, m[1], m[2], "");
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule